// File: doc/BRIEF.md
# Comparator Output Routing and Change Interrupt

This block is the digital back end behind a pair of analog comparators. It takes each raw comparator bit, applies a per-channel polarity inversion, and presents the result as read-only bits of a combined configuration/status word. A 3-bit mode field selects whether the two comparator results also drive two port pins. In that case they replace the port data latch on those pins. The per-pin tri-state bits remain the output enables in every mode.

A free-running four-phase sequencer splits each instruction cycle into phases Q1..Q4. A status-word read stores the comparator state in two stages. The first stage captures the live outputs in the Q1 phase of the read. The second stage copies the first in the Q3 phase of the read. A sticky change flag rises whenever the live outputs differ from the second stage, so software learns that a comparator has moved since its last read. The same mode field decides whether the comparator input pins read back as analog (zero) or as digital levels.

Phase sequencer states: PH_Q1, PH_Q2, PH_Q3 and PH_Q4. Transitions: PH_Q1→PH_Q2, PH_Q2→PH_Q3, PH_Q3→PH_Q4 and PH_Q4→PH_Q1, one per clock. Reset forces PH_Q1.

Top module: `cmp_outmux_top`

## Requirements
- R1: `phase` is one-hot, with bit 0 = Q1 through bit 3 = Q4. It reads Q1 during reset and advances Q1→Q2→Q3→Q4→Q1 on every clock after reset.
- R2: Status bits [7:6] equal `cmp_raw[1:0]` XOR the inversion bits [5:4], bit 6 belonging to channel 0. They follow `cmp_raw` without a clock.
- R3: A `cfg_wr` pulse loads the mode field [2:0] and the inversion bits [5:4] from `cfg_wdata`. Bit 3 always reads 0. Written values in bits [7:6] have no effect. Without `cfg_wr`, bits [5:0] hold their value.
- R4: After reset, mode and inversion are 0, the change flag is 0, and both pins carry `port_latch`.
- R5: When mode is 3'b110 or 3'b001, `pin_out` carries status bits [7:6] combinationally. In all other modes it carries `port_latch`.
- R6: `pin_oe` is the inverse of `tris` in every mode.
- R7: A read (`stat_rd` high) in a Q1 cycle captures status bits [7:6] into the first stage. A read in a Q3 cycle copies the first stage into the second stage, which is the reference for change detection.
- R8: `irq_flag` is set on the clock after the status outputs differ from the second stage. It stays set until `flag_clr`, and a set condition in the same cycle as `flag_clr` wins.
- R9: `port_rdata` returns `port_pin` only in mode 3'b111; in every other mode the comparator input pins are analog and read 0.
- R10: Asserting `rst_n` low clears the flag, both capture stages and the configuration at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 2 | Raw comparator results, one per channel |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Write data: mode [2:0], inversion [5:4] |
| stat_rd | input | 1 | Status-word read strobe |
| stat_rdata | output | 8 | Outputs [7:6], inversion [5:4], 0 [3], mode [2:0] |
| flag_clr | input | 1 | Clears the change flag |
| irq_flag | output | 1 | Sticky comparator change flag |
| port_latch | input | 2 | Port data latch for the two output pins |
| tris | input | 2 | Per-pin tri-state control, 1 = high impedance |
| pin_out | output | 2 | Data driven to the two pins |
| pin_oe | output | 2 | Output enable of the two pins |
| port_pin | input | 2 | Pad levels of the comparator input pins |
| port_rdata | output | 2 | Port read value of the comparator input pins |
| phase | output | 4 | One-hot Q1..Q4 phase enables |

## Verification
Every cycle, the assertions check the phase rotation, the inversion relation between raw inputs and status bits, and the holding of the configuration without a write. They also check the pin multiplexer choice for each mode, the output-enable mapping and the persistence of the change flag. The two-stage capture can only be shown by the bench's scenarios. These use reads that cover only Q1 or only Q3 and watch the flag. The bench scenarios also show the rejection of writes to the output bits, the set-over-clear priority, the analog zero read-back and the clearing by asynchronous reset.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int MODE_W = 3;
    localparam int NPH    = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } ph_e;

    localparam logic [MODE_W-1:0] MODE_PIN_A  = 3'b110;
    localparam logic [MODE_W-1:0] MODE_PIN_B  = 3'b001;
    localparam logic [MODE_W-1:0] MODE_DIGITAL = 3'b111;
endpackage

// File: rtl/cmp_phase_gen.sv
module cmp_phase_gen
    import cmp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    output logic [NPH-1:0] phase
);
    ph_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_Q1;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        phase   = '0;
        unique case (state_q)
            PH_Q1: begin phase = 4'b0001; state_d = PH_Q2; end
            PH_Q2: begin phase = 4'b0010; state_d = PH_Q3; end
            PH_Q3: begin phase = 4'b0100; state_d = PH_Q4; end
            PH_Q4: begin phase = 4'b1000; state_d = PH_Q1; end
        endcase
    end
endmodule

// File: rtl/cmp_chg_detect.sv
module cmp_chg_detect #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd,
    input  logic           en_first,
    input  logic           en_second,
    input  logic           clr,
    input  logic [NCH-1:0] live,
    output logic           flag
);
    logic [NCH-1:0] first_q;
    logic [NCH-1:0] second_q;
    logic           differ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= '0;
        else if (rd && en_first) first_q <= live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) second_q <= '0;
        else if (rd && en_second) second_q <= first_q;
    end

    assign differ = |(live ^ second_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (differ) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux #(
    parameter int NCH = 2
) (
    input  logic           sel_cmp,
    input  logic [NCH-1:0] cmp_out,
    input  logic [NCH-1:0] port_latch,
    input  logic [NCH-1:0] tris,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe
);
    for (genvar i = 0; i < NCH; i++) begin : g_pin
        assign pin_out[i] = sel_cmp ? cmp_out[i] : port_latch[i];
        assign pin_oe[i]  = ~tris[i];
    end
endmodule

// File: rtl/cmp_outmux_top.sv
module cmp_outmux_top
    import cmp_pkg::*;
#(
    parameter int NCH = 2,
    localparam int SW = 2 * NCH + 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmp_raw,
    input  logic           cfg_wr,
    input  logic [SW-1:0]  cfg_wdata,
    input  logic           stat_rd,
    output logic [SW-1:0]  stat_rdata,
    input  logic           flag_clr,
    output logic           irq_flag,
    input  logic [NCH-1:0] port_latch,
    input  logic [NCH-1:0] tris,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    input  logic [NCH-1:0] port_pin,
    output logic [NCH-1:0] port_rdata,
    output logic [NPH-1:0] phase
);
    localparam int INV_LO = 4;
    localparam int INV_HI = INV_LO + NCH - 1;

    logic [MODE_W-1:0] mode_q;
    logic [NCH-1:0]    inv_q;
    logic [NCH-1:0]    cmp_out;
    logic              sel_cmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            inv_q  <= '0;
        end else if (cfg_wr) begin
            mode_q <= cfg_wdata[MODE_W-1:0];
            inv_q  <= cfg_wdata[INV_HI:INV_LO];
        end
    end

    assign cmp_out    = cmp_raw ^ inv_q;
    assign sel_cmp    = (mode_q == MODE_PIN_A) || (mode_q == MODE_PIN_B);
    assign stat_rdata = {cmp_out, inv_q, 1'b0, mode_q};
    assign port_rdata = (mode_q == MODE_DIGITAL) ? port_pin : '0;

    cmp_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    cmp_chg_detect #(.NCH(NCH)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (stat_rd),
        .en_first  (phase[0]),
        .en_second (phase[2]),
        .clr       (flag_clr),
        .live      (cmp_out),
        .flag      (irq_flag)
    );

    cmp_pin_mux #(.NCH(NCH)) u_mux (
        .sel_cmp    (sel_cmp),
        .cmp_out    (cmp_out),
        .port_latch (port_latch),
        .tris       (tris),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );
endmodule

// File: rtl/cmp_outmux_chk.sv
module cmp_outmux_chk #(
    parameter int NCH = 2,
    localparam int SW = 2 * NCH + 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cmp_raw,
    input logic           cfg_wr,
    input logic           flag_clr,
    input logic [SW-1:0]  stat_rdata,
    input logic           irq_flag,
    input logic [NCH-1:0] port_latch,
    input logic [NCH-1:0] tris,
    input logic [NCH-1:0] pin_out,
    input logic [NCH-1:0] pin_oe,
    input logic [3:0]     phase
);
    logic [2:0]     mode;
    logic [NCH-1:0] inv;
    logic [NCH-1:0] outs;
    logic           pin_sel;

    assign mode    = stat_rdata[2:0];
    assign inv     = stat_rdata[NCH+3:4];
    assign outs    = stat_rdata[SW-1:NCH+4];
    assign pin_sel = (mode == 3'b110) || (mode == 3'b001);

    AST_PHASE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == {$past(phase[2:0]), $past(phase[3])}); // R1
    AST_INV_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        outs == (cmp_raw ^ inv)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(stat_rdata[NCH+3:0])); // R3
    AST_PIN_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel |-> pin_out == outs); // R5
    AST_PIN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sel |-> pin_out == port_latch); // R5
    AST_PIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe == ~tris); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag); // R8
endmodule

bind cmp_outmux_top cmp_outmux_chk #(.NCH(NCH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_raw    (cmp_raw),
    .cfg_wr     (cfg_wr),
    .flag_clr   (flag_clr),
    .stat_rdata (stat_rdata),
    .irq_flag   (irq_flag),
    .port_latch (port_latch),
    .tris       (tris),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .phase      (phase)
);

// File: tb/cmp_outmux_top_tb_top.sv
`timescale 1ns/1ps
module cmp_outmux_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       flag_clr = 1'b0;
    logic       irq_flag;
    logic [1:0] port_latch = 2'b10;
    logic [1:0] tris = 2'b00;
    logic [1:0] pin_out;
    logic [1:0] pin_oe;
    logic [1:0] port_pin = 2'b11;
    logic [1:0] port_rdata;
    logic [3:0] phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_outmux_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .flag_clr(flag_clr), .irq_flag(irq_flag), .port_latch(port_latch),
        .tris(tris), .pin_out(pin_out), .pin_oe(pin_oe), .port_pin(port_pin),
        .port_rdata(port_rdata), .phase(phase)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic wait_phase(input int idx);
        while (phase[idx] !== 1'b1) tick();
    endtask

    task automatic full_read();
        wait_phase(0);
        stat_rd = 1'b1;
        repeat (4) tick();
        stat_rd = 1'b0;
    endtask

    task automatic single_read(input int idx);
        wait_phase(idx);
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R4 mode/inv", stat_rdata[5:0], 8'h00);
        check("R4 flag", {7'b0, irq_flag}, 8'h00);
        check("R4 pins", {6'b0, pin_out}, {6'b0, port_latch});
        check("R1 reset phase", {4'b0, phase}, 8'h01);
    endtask

    task automatic t_phase();
        logic [3:0] p;
        p = phase;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R1 rotate", {4'b0, phase}, {4'b0, p[2:0], p[3]});
            p = {p[2:0], p[3]};
        end
    endtask

    task automatic t_inversion();
        cmp_raw = 2'b01;
        write_cfg(8'h00);
        check("R2 no inv", {6'b0, stat_rdata[7:6]}, 8'h01);
        write_cfg(8'h10);
        check("R2 inv ch0", {6'b0, stat_rdata[7:6]}, 8'h00);
        write_cfg(8'h20);
        check("R2 inv ch1", {6'b0, stat_rdata[7:6]}, 8'h03);
        cmp_raw = 2'b10; #1;
        check("R2 combinational", {6'b0, stat_rdata[7:6]}, 8'h00);
    endtask

    task automatic t_cfg_ro();
        cmp_raw = 2'b00;
        write_cfg(8'hCF);
        check("R3 ro bits and bit3", stat_rdata, 8'h07);
        repeat (3) tick();
        check("R3 hold", stat_rdata, 8'h07);
    endtask

    task automatic t_pins();
        port_latch = 2'b01; cmp_raw = 2'b10;
        write_cfg(8'h06);
        check("R5 mode110", {6'b0, pin_out}, 8'h02);
        cmp_raw = 2'b01; #1;
        check("R5 unsync", {6'b0, pin_out}, 8'h01);
        write_cfg(8'h01);
        check("R5 mode001", {6'b0, pin_out}, 8'h01);
        write_cfg(8'h11);
        check("R5 mode001 inv", {6'b0, pin_out}, 8'h00);
        cmp_raw = 2'b11;
        write_cfg(8'h02);
        check("R5 mode010 latch", {6'b0, pin_out}, 8'h01);
        tris = 2'b01; #1;
        check("R6 oe digital", {6'b0, pin_oe}, 8'h02);
        write_cfg(8'h06);
        tris = 2'b10; #1;
        check("R6 oe cmp mode", {6'b0, pin_oe}, 8'h01);
        tris = 2'b00;
    endtask

    task automatic t_port_read();
        port_pin = 2'b11;
        write_cfg(8'h02);
        check("R9 analog zero", {6'b0, port_rdata}, 8'h00);
        write_cfg(8'h07);
        check("R9 digital", {6'b0, port_rdata}, 8'h03);
    endtask

    task automatic t_flag();
        write_cfg(8'h00);
        cmp_raw = 2'b00;
        full_read();
        pulse_clr();
        check("R8 clear", {7'b0, irq_flag}, 8'h00);
        tick();
        check("R8 quiet", {7'b0, irq_flag}, 8'h00);
        @(negedge clk); cmp_raw = 2'b10; #1;
        check("R8 not before edge", {7'b0, irq_flag}, 8'h00);
        tick();
        check("R8 set", {7'b0, irq_flag}, 8'h01);
        pulse_clr();
        check("R8 set wins", {7'b0, irq_flag}, 8'h01);
        full_read();
        pulse_clr();
        check("R8 resync clear", {7'b0, irq_flag}, 8'h00);
    endtask

    task automatic t_two_stage();
        cmp_raw = 2'b00;
        full_read();
        pulse_clr();
        cmp_raw = 2'b01;
        single_read(2);
        pulse_clr();
        check("R7 Q3 only keeps old", {7'b0, irq_flag}, 8'h01);
        single_read(0);
        pulse_clr();
        check("R7 Q1 only no compare", {7'b0, irq_flag}, 8'h01);
        single_read(2);
        pulse_clr();
        check("R7 Q3 after Q1", {7'b0, irq_flag}, 8'h00);
    endtask

    task automatic t_async_reset();
        write_cfg(8'h16);
        cmp_raw = 2'b10;
        tick();
        check("R10 flag before", {7'b0, irq_flag}, 8'h01);
        #0.5 rst_n = 1'b0; #0.5;
        check("R10 async flag", {7'b0, irq_flag}, 8'h00);
        check("R10 async cfg", stat_rdata[5:0], 8'h00);
        cmp_raw = 2'b00;
        tick();
        rst_n = 1'b1;
        tick();
        check("R10 stays clear", {7'b0, irq_flag}, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        t_phase();
        t_inversion();
        t_cfg_ro();
        t_pins();
        t_port_read();
        t_flag();
        t_two_stage();
        t_async_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule